// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Fetch Flush

This block is the front end of a five-stage in-order pipeline that always guesses a branch is not taken. It holds the program counter and the fetch-to-decode pipeline register. It drives the fetch address to instruction memory and latches the returned word, together with the address of the following instruction, into the fetch-to-decode register.

When the word in decode is a branch-if-equal, the block compares the two register values that the register file returns for it. It does this with its own equality comparator in the decode stage, so the decision never waits for the execute-stage ALU. The register file lives outside the block. It is expected to return the value of the register named in bits [25:21] of `id_instr` on `rf_a` and the register named in bits [20:16] on `rf_b`.

If the values match, the branch is taken. The program counter is redirected to the branch target, and the one instruction fetched behind the branch is replaced by an all-zero no-op in the fetch-to-decode register. A taken branch therefore costs a single bubble cycle. A branch that is not taken costs nothing.

Top module: `dec_branch_unit`

## Requirements
- R1: While `rst_n` is low, `imem_addr` equals `RESET_PC` (default 0), and both `id_instr` and `id_pc_plus4` are 0.
- R2: In a cycle with `flush` low, `next_pc` equals `imem_addr + 4`, and `imem_addr` takes that value at the next rising edge.
- R3: In a cycle with `flush` low, the rising edge loads `imem_rdata` into `id_instr` and `imem_addr + 4` into `id_pc_plus4`.
- R4: `flush` is high exactly when `id_instr[31:26]` is 6'b000100 (branch-if-equal) and `rf_a` equals `rf_b`.
- R5: The branch target is `id_pc_plus4` plus the 16-bit field `id_instr[15:0]`, sign-extended to 32 bits and shifted left by two, with the sum taken modulo 2^32. In a cycle with `flush` high, `next_pc` equals this target and `imem_addr` takes it at the next edge.
- R6: In a cycle with `flush` high, the next edge writes the no-op 32'h00000000 into `id_instr` and 0 into `id_pc_plus4`, discarding the word being fetched.
- R7: A word whose opcode field is anything other than 6'b000100 never raises `flush`. This includes 6'b000101 with equal register values.
- R8: `flush` is never high in two consecutive cycles, so each taken branch discards exactly one instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Current program counter, used as the fetch address |
| imem_rdata | input | 32 | Instruction word fetched at `imem_addr` |
| rf_a | input | 32 | Register value for the rs field of `id_instr` |
| rf_b | input | 32 | Register value for the rt field of `id_instr` |
| id_instr | output | 32 | Instruction held in the fetch-to-decode register |
| id_pc_plus4 | output | 32 | Address of the word after `id_instr` |
| flush | output | 1 | High when the decode branch is taken, discarding the fetched word |
| next_pc | output | 32 | Program counter value to be loaded at the next edge |

## Verification
The assertions assume that instruction memory answers combinationally within the cycle. They also assume that `rf_a` and `rf_b` are functions of the current `id_instr` register fields, with no forwarding, so the comparator's inputs settle before the edge. The bench meets both assumptions by computing the fetched word arithmetically from `imem_addr`, and by deriving both register values from the rs and rt fields of `id_instr` plus a slowly changing epoch value. It updates that epoch only on the falling clock edge. Because the epoch changes, branches that would otherwise spin on themselves eventually fall through, which keeps the sweep moving across the program.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
  localparam int unsigned XW    = 32;
  localparam int unsigned OPW   = 6;
  localparam int unsigned OFFW  = 16;
  localparam int unsigned STEP  = 4;
  localparam logic [OPW-1:0] OP_BEQ = 6'b000100;
  localparam logic [XW-1:0]  NOP_WORD = '0;

  typedef logic [XW-1:0] word_t;

  // sequential fetch address
  function automatic word_t seq_addr(input word_t pc);
    return pc + word_t'(STEP);
  endfunction

  // target = following address + (sign-extended offset * 4)
  function automatic word_t branch_addr(input word_t pc4, input logic [OFFW-1:0] off);
    word_t ext;
    ext = {{(XW-OFFW){off[OFFW-1]}}, off};
    return pc4 + (ext << 2);
  endfunction

  function automatic logic opc_is_beq(input logic [OPW-1:0] op);
    return op == OP_BEQ;
  endfunction
endpackage

// File: rtl/dbu_pc.sv
module dbu_pc
  import dbu_pkg::*;
#(
  parameter word_t RESET_PC = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t pc_d,
  output word_t pc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/dbu_ifid.sv
module dbu_ifid
  import dbu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  kill,
  input  word_t fetch_word,
  input  word_t fetch_pc4,
  output word_t dec_word,
  output word_t dec_pc4
);
  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      dec_word <= NOP_WORD;
      dec_pc4  <= '0;
    end else begin
      dec_word <= fetch_word;
      dec_pc4  <= fetch_pc4;
    end
  end
endmodule

// File: rtl/dbu_resolve.sv
module dbu_resolve
  import dbu_pkg::*;
(
  input  logic [OPW-1:0]  op,
  input  logic [OFFW-1:0] off,
  input  word_t           src_a,
  input  word_t           src_b,
  input  word_t           dec_pc4,
  input  word_t           seq_pc,
  output logic            take,
  output word_t           target,
  output word_t           pc_sel
);
  logic same;
  assign same   = (src_a == src_b);
  assign take   = opc_is_beq(op) && same;
  assign target = branch_addr(dec_pc4, off);
  assign pc_sel = take ? target : seq_pc;
endmodule

// File: rtl/dec_branch_unit.sv
module dec_branch_unit
  import dbu_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  input  logic [31:0] rf_a,
  input  logic [31:0] rf_b,
  output logic [31:0] id_instr,
  output logic [31:0] id_pc_plus4,
  output logic        flush,
  output logic [31:0] next_pc
);
  word_t pc_now;
  word_t pc_inc;
  word_t br_tgt;
  word_t pc_nxt;
  logic  br_take;
  word_t dec_word;
  word_t dec_pc4;

  assign pc_inc = seq_addr(pc_now);

  dbu_pc #(.RESET_PC(RESET_PC)) u_pc (
    .clk  (clk),
    .rst_n(rst_n),
    .pc_d (pc_nxt),
    .pc_q (pc_now)
  );

  dbu_ifid u_ifid (
    .clk       (clk),
    .rst_n     (rst_n),
    .kill      (br_take),
    .fetch_word(imem_rdata),
    .fetch_pc4 (pc_inc),
    .dec_word  (dec_word),
    .dec_pc4   (dec_pc4)
  );

  dbu_resolve u_res (
    .op     (dec_word[XW-1 -: OPW]),
    .off    (dec_word[OFFW-1:0]),
    .src_a  (rf_a),
    .src_b  (rf_b),
    .dec_pc4(dec_pc4),
    .seq_pc (pc_inc),
    .take   (br_take),
    .target (br_tgt),
    .pc_sel (pc_nxt)
  );

  assign imem_addr   = pc_now;
  assign id_instr    = dec_word;
  assign id_pc_plus4 = dec_pc4;
  assign flush       = br_take;
  assign next_pc     = pc_nxt;
endmodule

// File: rtl/dbu_checker.sv
module dbu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [31:0] npc,
  input logic [31:0] fetched,
  input logic [31:0] dinstr,
  input logic [31:0] dpc4,
  input logic        fl,
  input logic [31:0] tgt,
  input logic [31:0] ra,
  input logic [31:0] rb
);
  a_r2_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !fl |=> pc == $past(pc) + 32'd4);

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !fl |=> (dinstr == $past(fetched)) && (dpc4 == $past(pc) + 32'd4));

  a_r4_cond: assert property (@(posedge clk) disable iff (!rst_n)
    fl |-> (dinstr[31:26] == 6'b000100) && (ra == rb));

  a_r5_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    fl |=> pc == $past(tgt));

  a_r5_tgt_dist: assert property (@(posedge clk) disable iff (!rst_n)
    fl |-> (tgt - dpc4) == {{14{dinstr[15]}}, dinstr[15:0], 2'b00});

  a_r6_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    fl |=> (dinstr == 32'h0) && (dpc4 == 32'h0));

  a_r7_other_op: assert property (@(posedge clk) disable iff (!rst_n)
    (dinstr[31:26] != 6'b000100) |-> !fl);

  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    fl |=> !fl);

  a_r2_npc_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !fl |-> npc == pc + 32'd4);
endmodule

bind dec_branch_unit dbu_checker u_dbu_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .pc     (imem_addr),
  .npc    (next_pc),
  .fetched(imem_rdata),
  .dinstr (id_instr),
  .dpc4   (id_pc_plus4),
  .fl     (flush),
  .tgt    (br_tgt),
  .ra     (rf_a),
  .rb     (rf_b)
);

// File: tb/test_dec_branch_unit.sv
`timescale 1ns/1ps
module test_dec_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, rf_a, rf_b, id_instr, id_pc_plus4, next_pc;
  logic        flush;
  int unsigned epoch = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  dec_branch_unit i_dec_branch_unit (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .rf_a(rf_a), .rf_b(rf_b), .id_instr(id_instr), .id_pc_plus4(id_pc_plus4),
    .flush(flush), .next_pc(next_pc)
  );

  // program generated arithmetically from the word index
  function automatic logic [31:0] prog(input logic [31:0] a);
    int i;
    logic [15:0] off;
    logic [4:0] rs, rt;
    i = int'(a[7:2]);
    if (i % 3 == 0) begin
      rs = 5'(i % 8);
      rt = 5'((i * 5 + 1) % 8);
      if (i % 9 == 0)   off = 16'h8000;
      else if (i == 30) off = 16'h7FFF;
      else              off = 16'(i % 5) - 16'd1;
      return {6'b000100, rs, rt, off};
    end else if (i % 3 == 1) begin
      rs = 5'(i % 8);
      return {6'b000101, rs, rs, 16'h0003};
    end
    return 32'h0000_0020 | (32'(i) << 11);
  endfunction

  function automatic logic [31:0] regval(input logic [4:0] r, input int unsigned e);
    return 32'hA5A5_0000 + 32'(((int'(r) + int'(e)) % 8) / 2);
  endfunction

  assign imem_rdata = prog(imem_addr);
  assign rf_a = regval(id_instr[25:21], epoch);
  assign rf_b = regval(id_instr[20:16], epoch);

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] e_pc, e_ir, e_pc4, e_next, e_tgt;
    logic        e_take;
    int n_taken = 0, n_nottaken = 0, n_bne_eq = 0, n_back = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk32("R1 pc", imem_addr, 32'h0);
    chk32("R1 id_instr", id_instr, 32'h0);
    chk32("R1 id_pc_plus4", id_pc_plus4, 32'h0);
    rst_n = 1'b1;
    e_pc = 32'h0; e_ir = 32'h0; e_pc4 = 32'h0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      epoch = (cyc / 7) % 8;
      #1;
      e_take = (e_ir[31:26] == 6'b000100) &&
               (regval(e_ir[25:21], epoch) == regval(e_ir[20:16], epoch));
      e_tgt  = e_pc4 + {{14{e_ir[15]}}, e_ir[15:0], 2'b00};
      e_next = e_take ? e_tgt : e_pc + 32'd4;
      chk32("R2 pc", imem_addr, e_pc);
      chk32("R3/R6 id_instr", id_instr, e_ir);
      chk32("R3/R6 id_pc_plus4", id_pc_plus4, e_pc4);
      chk32("R4/R7/R8 flush", {31'd0, flush}, {31'd0, e_take});
      chk32("R2/R5 next_pc", next_pc, e_next);
      if (e_take) begin
        n_taken++;
        if (e_ir[15]) n_back++;
      end else if (e_ir[31:26] == 6'b000100) n_nottaken++;
      if (e_ir[31:26] == 6'b000101) n_bne_eq++;
      if (e_take) begin e_ir = 32'h0; e_pc4 = 32'h0; end
      else        begin e_ir = prog(e_pc); e_pc4 = e_pc + 32'd4; end
      e_pc = e_next;
      @(negedge clk);
    end
    // coverage of the cases the requirements call out
    chk32("R5 taken seen", {31'd0, n_taken > 0}, 32'd1);
    chk32("R5 backward taken seen", {31'd0, n_back > 0}, 32'd1);
    chk32("R2 not-taken beq seen", {31'd0, n_nottaken > 0}, 32'd1);
    chk32("R7 other opcode seen", {31'd0, n_bne_eq > 0}, 32'd1);
    summary();
    $finish;
  end
endmodule